// File: doc/BRIEF.md
# Dual-Mode Transmit Character Queue Write Port

This block accepts 14-bit characters (data plus command bits) from a host bus and holds them in a 256-entry queue. A formatter on a separate reference clock drains the queue. A static mode input selects one of two handshake timing models for the host side. In bus timing, the write enable and the empty and full status pins are active low, and a character is captured on the same edge that samples the enable. In cascade timing, the same pins are active high, and the character is captured one write-clock edge after the enable was sampled. This lets a source that raises its write strobe a cycle before its data is valid connect directly, including a second synchronous queue chained in front for extra depth.

Before any write is accepted, the port must be addressed. While the enable is deasserted, each write-clock edge loads the address-hit input into an "addressed" state. Once addressed, every edge that samples the enable asserted is a write request. The addressed state is held for as long as the enable stays asserted.

Occupancy flags are computed in the write-clock domain. The read pointer reaches that domain in Gray code through a two-flop synchronizer, and the write pointer reaches the read domain the same way. Because of this, a flag caused by a read changes only after a few write-clock cycles.

Top module: `txq_write_port`

## Requirements
- R1: After reset the queue is empty. Empty reads asserted, full and half-full read deasserted, and `rvalid` is 0.
- R2: With `cascade` = 0, `wen_pin`, `empty_pin` and `full_pin` are active low: a value of 0 means asserted.
- R3: With `cascade` = 1, `wen_pin`, `empty_pin` and `full_pin` are active high. `cascade` only changes while the block is in reset.
- R4: An edge that samples the enable asserted stores nothing unless an earlier edge, with the enable deasserted, sampled `addr_hit` = 1.
- R5: In bus timing, once addressed, every write-clock edge that samples the enable asserted stores the `wdata` present at that same edge.
- R6: In cascade timing, once addressed, an edge that samples the enable asserted causes the `wdata` present at the following edge to be stored.
- R7: Full asserts when 256 characters are held. A write at an edge where full is asserted is dropped, and the stored contents stay unchanged.
- R8: `half_pin` (always active high) is 1 exactly when the write-side occupancy is 128 or more.
- R9: Each `rclk` edge that samples `rd_req` = 1 while data is available sets `rvalid` = 1 for one cycle, with `rdata` holding the oldest character. Characters come out in write order. A request while empty leaves `rvalid` at 0.
- R10: After the queue has been fully read, empty reasserts on the write side within a few write-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Write-domain reset, active low |
| cascade | input | 1 | Static timing mode: 0 bus, 1 cascade |
| addr_hit | input | 1 | Address match from the host bus |
| wen_pin | input | 1 | Write enable, polarity set by mode |
| wdata | input | 14 | Character (data and command bits) |
| empty_pin | output | 1 | Queue empty, polarity set by mode |
| full_pin | output | 1 | Queue full, polarity set by mode |
| half_pin | output | 1 | Occupancy at least half, active high |
| rclk | input | 1 | Reference (read) clock |
| rrst_n | input | 1 | Read-domain reset, active low |
| rd_req | input | 1 | Read request from the formatter |
| rdata | output | 14 | Character read out |
| rvalid | output | 1 | `rdata` holds a new character |

## Verification
The assertions take it for granted that `cascade` is held steady outside reset. They also assume that `rd_req` is the only thing that can produce a read result, so `rvalid` must follow a request on the previous `rclk` edge.

The stimulus changes the mode only while both resets are held. It drives every input on the falling edge of its own clock. It runs the write phases and the drain phases apart from each other, so the occupancy seen on the write side is exact whenever the flags are checked.

// File: rtl/txq_write_port.sv
`timescale 1ns/1ps
module txq_write_port #(
  parameter int DW = 14,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          cascade,
  input  logic          addr_hit,
  input  logic          wen_pin,
  input  logic [DW-1:0] wdata,
  output logic          empty_pin,
  output logic          full_pin,
  output logic          half_pin,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_req,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    for (int i = 0; i < PW; i++) g2b[i] = ^(g >> i);
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic en_act, addressed, pend, wr_try, wr_fire;
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, occ, wbin_n;
  logic full_i, wempty;

  assign en_act = cascade ? wen_pin : ~wen_pin;
  assign wr_try = cascade ? pend : (addressed & en_act);

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      addressed <= 1'b0;
      pend      <= 1'b0;
    end else begin
      if (!en_act) addressed <= addr_hit;
      pend <= addressed & en_act;
    end

  assign occ     = wbin - g2b(rg_s2);
  assign full_i  = occ[AW];
  assign wempty  = (occ == '0);
  assign wr_fire = wr_try & ~full_i;
  assign wbin_n  = wbin + PW'(wr_fire);

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
    end

  always_ff @(posedge wclk)
    if (wr_fire) mem[wbin[AW-1:0]] <= wdata;

  assign empty_pin = cascade ? wempty : ~wempty;
  assign full_pin  = cascade ? full_i : ~full_i;
  assign half_pin  = (occ >= PW'(DEPTH / 2));

  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2, rbin_n;
  logic rempty, rd_fire;

  assign rempty  = (rgray == wg_s2);
  assign rd_fire = rd_req & ~rempty;
  assign rbin_n  = rbin + PW'(rd_fire);

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wg_s1  <= '0;
      wg_s2  <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rbin   <= rbin_n;
      rgray  <= rbin_n ^ (rbin_n >> 1);
      wg_s1  <= wgray;
      wg_s2  <= wg_s1;
      rvalid <= rd_fire;
      if (rd_fire) rdata <= mem[rbin[AW-1:0]];
    end
endmodule

module txq_write_port_chk (
  input logic wclk,
  input logic wrst_n,
  input logic rclk,
  input logic rrst_n,
  input logic cascade,
  input logic empty_pin,
  input logic full_pin,
  input logic half_pin,
  input logic rd_req,
  input logic rvalid
);
  logic full_act, empty_act;
  assign full_act  = cascade ? full_pin : ~full_pin;
  assign empty_act = cascade ? empty_pin : ~empty_pin;

  p_full_implies_half_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
    full_act |-> half_pin);
  p_empty_not_half_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
    empty_act |-> !half_pin);
  p_no_overflow_r7: assert property (@(posedge wclk) disable iff (!wrst_n)
    !(full_act && empty_act));
  p_mode_static_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    $stable(cascade));
  p_valid_needs_req_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
    rvalid |-> $past(rd_req));
endmodule

bind txq_write_port txq_write_port_chk u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .cascade(cascade), .empty_pin(empty_pin), .full_pin(full_pin),
  .half_pin(half_pin), .rd_req(rd_req), .rvalid(rvalid)
);

// File: tb/tb_txq_write_port.sv
`timescale 1ns/1ps
module tb_txq_write_port;
  localparam int WCLK_P = 10;
  localparam int RCLK_P = 14;
  localparam int DW     = 14;
  localparam int DEPTH  = 256;

  logic wclk = 0, rclk = 0;
  logic wrst_n, rrst_n, cascade, addr_hit, wen_pin, rd_req;
  logic [DW-1:0] wdata;
  logic empty_pin, full_pin, half_pin, rvalid;
  logic [DW-1:0] rdata;

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];
  bit addr_m, pend_m, mode;

  always #(WCLK_P/2) wclk = ~wclk;
  always #(RCLK_P/2) rclk = ~rclk;

  txq_write_port dut (
    .wclk(wclk), .wrst_n(wrst_n), .cascade(cascade), .addr_hit(addr_hit),
    .wen_pin(wen_pin), .wdata(wdata), .empty_pin(empty_pin), .full_pin(full_pin),
    .half_pin(half_pin), .rclk(rclk), .rrst_n(rrst_n), .rd_req(rd_req),
    .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic pin_of(bit active);
    return mode ? active : ~active;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic flags(string tag);
    chk(tag, "empty_pin", 32'(empty_pin), 32'(pin_of(q.size() == 0)));
    chk("R7", "full_pin", 32'(full_pin), 32'(pin_of(q.size() == DEPTH)));
    chk("R8", "half_pin", 32'(half_pin), 32'(q.size() >= DEPTH/2));
  endtask

  task automatic wcyc(bit en, bit hit, logic [DW-1:0] d);
    @(negedge wclk);
    wen_pin = mode ? en : ~en;
    addr_hit = hit;
    wdata = d;
    @(posedge wclk);
    if (mode) begin
      if (pend_m && q.size() < DEPTH) q.push_back(d);
      pend_m = addr_m && en;
    end else if (addr_m && en && q.size() < DEPTH) q.push_back(d);
    if (!en) addr_m = hit;
    #1;
    flags(mode ? "R3" : "R2");
  endtask

  task automatic do_reset(bit m);
    mode = m; cascade = m;
    wrst_n = 0; rrst_n = 0; rd_req = 0; addr_hit = 0; wdata = '0;
    wen_pin = m ? 1'b0 : 1'b1;
    repeat (4) @(posedge wclk);
    @(negedge wclk) wrst_n = 1;
    @(negedge rclk) rrst_n = 1;
    q.delete(); addr_m = 0; pend_m = 0;
    #1;
    flags("R1");
    chk("R1", "rvalid", 32'(rvalid), 32'd0);
  endtask

  task automatic drain(string tag);
    int n;
    repeat (6) @(posedge rclk);
    n = q.size() + 2;
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] e;
      bit ev;
      @(negedge rclk) rd_req = 1;
      @(posedge rclk);
      ev = (q.size() > 0);
      e = ev ? q.pop_front() : '0;
      #1;
      chk("R9", "rvalid", 32'(rvalid), 32'(ev));
      if (ev) chk(tag, "rdata", 32'(rdata), 32'(e));
    end
    @(negedge rclk) rd_req = 0;
    repeat (6) wcyc(0, 0, '0);
    chk("R10", "empty after drain", 32'(empty_pin), 32'(pin_of(1)));
  endtask

  initial begin
    #(WCLK_P * 100000);
    errors++;
    $display("FAIL R1 watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int m = 0; m < 2; m++) begin
      do_reset(bit'(m));
      // R4: enable without prior address stores nothing
      wcyc(0, 0, '0);
      repeat (3) wcyc(1, 0, 14'h1abc);
      chk("R4", "empty without address", 32'(empty_pin), 32'(pin_of(1)));
      // R5 / R6: short directed burst with distinct data
      wcyc(0, 1, '0);
      for (int i = 0; i < 5; i++) wcyc(1, 1, DW'(14'h100 + i));
      wcyc(0, 1, 14'h2222);
      if (m == 0) begin
        chk("R5", "bus burst count", 32'(q.size()), 32'd5);
        chk("R5", "bus first word", 32'(q[0]), 32'h100);
      end else begin
        chk("R6", "cascade first word", 32'(q[0]), 32'h101);
        chk("R6", "cascade last word", 32'(q[q.size()-1]), 32'h2222);
      end
      drain(m == 0 ? "R5" : "R6");
      // R7 / R8: fill past full
      wcyc(0, 1, '0);
      for (int i = 0; i < DEPTH + 6; i++) wcyc(1, 1, DW'($urandom));
      wcyc(0, 0, '0);
      chk("R7", "held at full", 32'(q.size()), 32'(DEPTH));
      drain("R7");
      // random traffic
      for (int i = 0; i < 400; i++)
        wcyc(($urandom % 4) != 0, ($urandom % 8) != 0, DW'($urandom));
      wcyc(0, 0, '0);
      drain("R9");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule